// File: doc/BRIEF.md
# Timer Output Pin Control

This block turns the activity of two timer channels into a single waveform on a general-purpose output pin. Each channel supplies a single-cycle underflow pulse, a PWM waveform, a mode bit and a clear strobe. In divide mode, a phase flip-flop for that channel inverts on every underflow. The result is a square wave at half the underflow rate. In PWM mode, the channel's PWM waveform goes straight through instead.

A select register chooses which channel reaches the pin. When the two timers run cascaded as one 16-bit timer, software must select timer 1. An enable register gates the chosen waveform: while it is off, the pin rests high. The pin also has a data register and a high-impedance control of its own. The data register ANDs its value into the pin level. The high-impedance control releases the pad entirely.

Software writes the four registers through a small address / write-enable / write-data bus. The pin is modelled as a tristate pad, with its level and drive-enable also available as plain outputs.

Top module: `tmr_out_pin`

## Requirements
- R1: After reset the select register is 0, the enable register is 0, the data register is 1 and the high-impedance register is 0. Both phase flip-flops are 0, so the pin is driven (drive-enable 1) at level 1.
- R2: With a channel's mode bit at 0 (divide mode), the channel's signal is its phase flip-flop. The flip-flop inverts on each rising clock edge where that channel's underflow input is 1 and its clear input is 0. It holds its value otherwise.
- R3: With a channel's mode bit at 1 (PWM mode), the channel's signal equals its PWM input in the same cycle, without a register stage.
- R4: A write to address 0 loads the select register from write-data bit 0. Value 0 routes timer 0 to the pin and value 1 routes timer 1. Activity on the unselected channel leaves the pin unchanged.
- R5: A write to address 1 loads the enable register from bit 0. With enable 1 the pin level is the selected channel's signal. With enable 0 the pin level is 1 whatever the channels do.
- R6: A write to address 2 loads the data register from bit 0. The pin level is the gated timer level ANDed with this register, so a 0 here drives the pin low.
- R7: A write to address 3 loads the high-impedance register from bit 0. While it is 1, drive-enable is 0 and the pad floats. While it is 0, the pad carries the pin level.
- R8: A clear strobe forces that channel's phase flip-flop to 0 on the next edge. This holds even when an underflow arrives in the same cycle.
- R9: The phase flip-flop keeps inverting on underflows while its channel is in PWM mode. Returning to divide mode therefore shows the phase built up meanwhile.
- R10: While write-enable is 0, no register changes, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 select, 1 enable, 2 data, 3 high-impedance) |
| wr_data | input | SEL_W (1) | Write data; bit 0 used by every register |
| tmr_uflow | input | NUM_TMR (2) | Single-cycle underflow pulse per timer |
| tmr_pwm | input | NUM_TMR (2) | PWM waveform per timer |
| tmr_pwm_mode | input | NUM_TMR (2) | 1 selects PWM pass-through per timer |
| tmr_clr | input | NUM_TMR (2) | Clears the phase flip-flop (timer reload or stop) |
| pin_out | output | 1 | Level the pad drives |
| pin_oe | output | 1 | Pad drive-enable |
| pin_pad | inout | 1 | Tristate pad model |

## Verification
The awkward case is hidden phase. The pin shows only one channel, and only in one mode. A phase flip-flop can therefore change while nothing at the pin reveals it: the channel may be unselected, in PWM mode, or masked by the enable or data registers. The bench keeps its own model of both phases. It sends underflows into a masked channel, then unmasks it by changing select, mode or enable, and compares the pin against the model. A clear and an underflow are also driven in the same cycle to confirm that the clear wins.

// File: rtl/tout_pkg.sv
package tout_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADR_CHSEL = 2'd0,
    ADR_OUTEN = 2'd1,
    ADR_PDATA = 2'd2,
    ADR_PHIZ  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic hiz;
    logic data;
    logic en;
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{hiz: 1'b0, data: 1'b1, en: 1'b0};

  // Next phase of a divide-by-two stage: clear dominates, underflow inverts.
  function automatic logic next_phase(input logic q, input logic uflow, input logic clr);
    return clr ? 1'b0 : (q ^ uflow);
  endfunction

  // Pin level: disabled output rests high, then ANDed with the port data bit.
  function automatic logic pad_level(input logic sig, input logic en, input logic data);
    return (en ? sig : 1'b1) & data;
  endfunction

endpackage

// File: rtl/tout_regs.sv
module tout_regs
  import tout_pkg::*;
#(
  parameter int unsigned SEL_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [SEL_W-1:0]      wr_data,
  output logic [SEL_W-1:0]      sel_q,
  output port_cfg_t             cfg_q
);

  reg_addr_e addr_dec;
  logic      wr_sel;
  logic      wr_cfg;

  assign addr_dec = reg_addr_e'(wr_addr);
  assign wr_sel   = wr_en && (addr_dec == ADR_CHSEL);
  assign wr_cfg   = wr_en && (addr_dec != ADR_CHSEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cfg_q <= CFG_RESET;
    end else begin
      if (wr_sel) sel_q <= wr_data;
      if (wr_cfg) begin
        case (addr_dec)
          ADR_OUTEN: cfg_q.en   <= wr_data[0];
          ADR_PDATA: cfg_q.data <= wr_data[0];
          ADR_PHIZ:  cfg_q.hiz  <= wr_data[0];
          default:   cfg_q      <= cfg_q;
        endcase
      end
    end
  end

  assert_sel_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_q == $past(wr_data));

  assert_en_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> cfg_q.en == $past(wr_data[0]));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sel_q) && $stable(cfg_q)));

endmodule

// File: rtl/tout_chan.sv
module tout_chan
  import tout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic uflow,
  input  logic clr,
  input  logic pwm,
  input  logic pwm_mode,
  output logic phase_q,
  output logic chan_sig
);

  logic toggle_evt;
  logic clear_evt;

  assign toggle_evt = uflow & ~clr;
  assign clear_evt  = clr;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= next_phase(phase_q, uflow, clr);
  end

  assign chan_sig = pwm_mode ? pwm : phase_q;

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_evt |=> phase_q != $past(phase_q));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uflow && !clr) |=> $stable(phase_q));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !phase_q);

endmodule

// File: rtl/tout_pad.sv
module tout_pad
  import tout_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sig,
  input  port_cfg_t cfg,
  output logic      pin_out,
  output logic      pin_oe,
  inout  wire       pin_pad
);

  assign pin_out = pad_level(sig, cfg.en, cfg.data);
  assign pin_oe  = ~cfg.hiz;
  assign pin_pad = pin_oe ? pin_out : 1'bz;

  assert_hiz_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.hiz |-> !pin_oe);

  assert_data_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.data |-> !pin_out);

endmodule

// File: rtl/tmr_out_pin.sv
module tmr_out_pin
  import tout_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  localparam int unsigned SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [SEL_W-1:0]      wr_data,
  input  logic [NUM_TMR-1:0]    tmr_uflow,
  input  logic [NUM_TMR-1:0]    tmr_pwm,
  input  logic [NUM_TMR-1:0]    tmr_pwm_mode,
  input  logic [NUM_TMR-1:0]    tmr_clr,
  output logic                  pin_out,
  output logic                  pin_oe,
  inout  wire                   pin_pad
);

  logic [SEL_W-1:0]   sel_q;
  port_cfg_t          cfg_q;
  logic [NUM_TMR-1:0] phase_q;
  logic [NUM_TMR-1:0] chan_sig;
  logic               sel_sig;
  logic               sel_mode;
  logic               sel_pwm;

  tout_regs #(.SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel_q   (sel_q),
    .cfg_q   (cfg_q)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
    tout_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .uflow    (tmr_uflow[g]),
      .clr      (tmr_clr[g]),
      .pwm      (tmr_pwm[g]),
      .pwm_mode (tmr_pwm_mode[g]),
      .phase_q  (phase_q[g]),
      .chan_sig (chan_sig[g])
    );
  end

  assign sel_sig  = chan_sig[sel_q];
  assign sel_mode = tmr_pwm_mode[sel_q];
  assign sel_pwm  = tmr_pwm[sel_q];

  tout_pad u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig     (sel_sig),
    .cfg     (cfg_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pad (pin_pad)
  );

  assert_pwm_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.data && sel_mode) |-> pin_out == sel_pwm);

  assert_disabled_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.en && cfg_q.data) |-> pin_out);

  assert_divide_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.data && !sel_mode) |-> pin_out == phase_q[sel_q]);

endmodule

// File: tb/tmr_out_pin_test.sv
module tmr_out_pin_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [0:0] wr_data = '0;
  logic [1:0] tmr_uflow = '0;
  logic [1:0] tmr_pwm = '0;
  logic [1:0] tmr_pwm_mode = '0;
  logic [1:0] tmr_clr = '0;
  logic       pin_out;
  logic       pin_oe;
  wire        pin_pad;

  int n_checks = 0;
  int n_fails  = 0;
  logic ph0 = 1'b0;
  logic ph1 = 1'b0;

  always #10 clk = ~clk;

  tmr_out_pin uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .tmr_uflow    (tmr_uflow),
    .tmr_pwm      (tmr_pwm),
    .tmr_pwm_mode (tmr_pwm_mode),
    .tmr_clr      (tmr_clr),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .pin_pad      (pin_pad)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic pulse(input int ch, input logic clr_too);
    @(negedge clk);
    tmr_uflow[ch] = 1'b1;
    tmr_clr[ch]   = clr_too;
    @(negedge clk);
    tmr_uflow[ch] = 1'b0;
    tmr_clr[ch]   = 1'b0;
    if (ch == 0) ph0 = clr_too ? 1'b0 : ~ph0;
    else         ph1 = clr_too ? 1'b0 : ~ph1;
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset pin level", pin_out, 1'b1);
    chk("R1 reset drive", pin_oe, 1'b1);
    chk("R1 reset pad", pin_pad, 1'b1);
    wr(2'd1, 1'b1);
    chk("R1 phase0 reset 0", pin_out, 1'b0);
    wr(2'd0, 1'b1);
    chk("R1 phase1 reset 0", pin_out, 1'b0);
    wr(2'd0, 1'b0);
  endtask

  task automatic t_divide;
    for (int i = 0; i < 4; i++) begin
      pulse(0, 1'b0);
      chk("R2 divide toggle", pin_out, ph0);
    end
    pulse(0, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk("R2 divide hold", pin_out, 1'b1);
  endtask

  task automatic t_pwm;
    @(negedge clk);
    tmr_pwm_mode[0] = 1'b1; tmr_pwm[0] = 1'b0;
    #1;
    chk("R3 pwm low", pin_out, 1'b0);
    tmr_pwm[0] = 1'b1;
    #1;
    chk("R3 pwm high same cycle", pin_out, 1'b1);
    pulse(0, 1'b0);
    pulse(0, 1'b0);
    pulse(0, 1'b0);
    tmr_pwm[0] = 1'b1;
    #1;
    chk("R3 pwm ignores phase", pin_out, 1'b1);
    @(negedge clk);
    tmr_pwm_mode[0] = 1'b0;
    #1;
    chk("R9 phase kept counting", pin_out, ph0);
    chk("R9 phase value", pin_out, 1'b0);
  endtask

  task automatic t_select;
    wr(2'd0, 1'b1);
    chk("R4 select timer1", pin_out, ph1);
    pulse(0, 1'b0);
    chk("R4 unselected ignored", pin_out, ph1);
    pulse(1, 1'b0);
    chk("R4 timer1 toggles pin", pin_out, 1'b1);
    wr(2'd0, 1'b0);
    chk("R4 back to timer0", pin_out, ph0);
  endtask

  task automatic t_enable;
    wr(2'd1, 1'b0);
    pulse(0, 1'b0);
    chk("R5 disabled high a", pin_out, 1'b1);
    pulse(0, 1'b0);
    chk("R5 disabled high b", pin_out, 1'b1);
    wr(2'd1, 1'b1);
    chk("R5 enabled follows", pin_out, ph0);
  endtask

  task automatic t_data;
    if (!ph0) pulse(0, 1'b0);
    chk("R6 setup high", pin_out, 1'b1);
    wr(2'd2, 1'b0);
    chk("R6 data 0 forces low", pin_out, 1'b0);
    wr(2'd1, 1'b0);
    chk("R6 data 0 low while disabled", pin_out, 1'b0);
    wr(2'd2, 1'b1);
    chk("R6 data 1 restores high", pin_out, 1'b1);
    wr(2'd1, 1'b1);
  endtask

  task automatic t_hiz;
    wr(2'd3, 1'b1);
    chk("R7 hiz releases", pin_oe, 1'b0);
    wr(2'd3, 1'b0);
    chk("R7 drive again", pin_oe, 1'b1);
    chk("R7 pad carries level", pin_pad, pin_out);
  endtask

  task automatic t_clear;
    if (!ph0) pulse(0, 1'b0);
    chk("R8 setup phase 1", pin_out, 1'b1);
    pulse(0, 1'b1);
    chk("R8 clear beats underflow", pin_out, 1'b0);
    pulse(0, 1'b0);
    @(negedge clk);
    tmr_clr[0] = 1'b1;
    @(negedge clk);
    tmr_clr[0] = 1'b0;
    ph0 = 1'b0;
    #1;
    chk("R8 plain clear", pin_out, 1'b0);
  endtask

  task automatic t_nowrite;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd1; wr_data = 1'b0;
    @(negedge clk);
    wr_addr = 2'd3; wr_data = 1'b1;
    @(negedge clk);
    wr_addr = 2'd0; wr_data = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 no write drive", pin_oe, 1'b1);
    pulse(0, 1'b0);
    chk("R10 still enabled timer0", pin_out, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divide();
    t_pwm();
    t_select();
    t_enable();
    t_data();
    t_hiz();
    t_clear();
    t_nowrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule